// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Unit

This unit holds the sticky status bits of an I2C controller and raises its single interrupt request. The protocol engine sends it one-cycle event pulses: start and stop detection, arbitration loss, the end of an incoming address, byte completion at two points in the byte, and bus timeouts. The unit also takes the enable bits and the configured addresses, and turns all of these into a status byte plus a pair of start/stop-detected flags.

Software reaches the unit through a small synchronous register port. Writing a 1 to a flag bit of the status or start/stop register clears that flag. Any write to the control-register offset clears the range-match bit. Reads are combinational from the current address. Line sampling, shifting and bit timing belong to the engine and are not part of this unit.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset every status bit, both start/stop flags and `irq` are 0.
- R2: Status bit 5 (bus busy) sets on `evStart` and clears on `evStop`. A start in the same cycle as a stop wins. Writes to it have no effect.
- R3: Status bit 4 (arbitration lost) sets on `evArbLost` and stays set until a write to offset 0 with bit 4 = 1.
- R4: Status bit 3 (range match) sets on `evAddr` only when `rangeEn` and `intEn` are both 1 and one of two conditions holds. Either `rxAddr` is nonzero and equals `rangeAddr`, or `ownAddr < rxAddr < rangeAddr`.
- R5: Any write to offset 1 clears status bit 3, whatever the data.
- R6: On an address match (primary, range, or `matchAux`), status bit 2 takes `rxRw`. An address with no match leaves it unchanged.
- R7: With `fastAck` = 0, byte completion sets status bit 1 (interrupt pending) on `evAckDone` and not on `evDataDone`. With `fastAck` = 1 the reverse holds.
- R8: Status bit 1 also sets on any address match, on arbitration loss, and on `evTmo` with `tmoKind` of 0 or 3. A `tmoKind` of 1 (clock-high) or 2 (data-high) does not set it. Writing 1 to bit 1 at offset 0 clears it.
- R9: `evStart` and `evStop` set bits 1 and 0 of offset 2, and each of those bits is cleared by writing 1 to it. While `ssIntEn` = 1 and either flag is set, clearing bit 1 at offset 0 has no lasting effect: the bit is set again.
- R10: Status bit 0 takes `ackN` on every `evAckDone`, regardless of `fastAck`.
- R11: When a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R12: `irq` is 1 exactly when status bit 1 is 1 and `intEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evStart | input | 1 | Start condition detected |
| evStop | input | 1 | Stop condition detected |
| evArbLost | input | 1 | Arbitration lost |
| evAddr | input | 1 | Calling address received |
| rxAddr | input | ADDR_W | Received calling address |
| rxRw | input | 1 | Received R/W bit |
| matchAux | input | 1 | Alert, second or general-call match, qualified by evAddr |
| evDataDone | input | 1 | Eight data bits finished |
| evAckDone | input | 1 | ACK/NACK bit finished |
| ackN | input | 1 | Sampled acknowledge, 1 = NACK |
| evTmo | input | 1 | Timeout event |
| tmoKind | input | 2 | 0 clock-low, 1 clock-high, 2 data-high, 3 cumulative |
| ownAddr | input | ADDR_W | Primary slave address |
| rangeAddr | input | ADDR_W | Range upper address |
| rangeEn | input | 1 | Range matching enable |
| intEn | input | 1 | Global interrupt enable |
| ssIntEn | input | 1 | Start/stop interrupt enable |
| fastAck | input | 1 | Byte completion before the ACK bit |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| irq | output | 1 | Interrupt request |

## Verification
Each flag is a single register that software reads directly, so a wrong next-state value appears at offset 0 or 2 in the first read after the clocking edge. One example is a clear that beats a set, or a range test with the wrong bound. An interrupt flag that drops when it should be re-raised shows up the same way, and `irq` shows it too, in that same cycle. A missed sticky hold shows up later, when a read after unrelated traffic finds the bit gone.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] OFF_STAT = 2'd0;
  localparam logic [1:0] OFF_CTRL = 2'd1;
  localparam logic [1:0] OFF_SSF  = 2'd2;

  localparam int B_BUSY  = 5;
  localparam int B_ARBL  = 4;
  localparam int B_RANGE = 3;
  localparam int B_SRW   = 2;
  localparam int B_IFLAG = 1;
  localparam int B_RXAK  = 0;
  localparam int B_STARTF = 1;
  localparam int B_STOPF  = 0;

  typedef struct packed {
    logic setBusy;
    logic clrBusy;
    logic setArbl;
    logic clrArbl;
    logic setRange;
    logic clrRange;
    logic ldSrw;
    logic srwVal;
    logic setIflag;
    logic clrIflag;
    logic ldRxak;
    logic rxakVal;
    logic setStartF;
    logic clrStartF;
    logic setStopF;
    logic clrStopF;
  } statStrobes_t;
endpackage

// File: rtl/i2c_stat_ctrl.sv
module i2c_stat_ctrl
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evArbLost,
  input  logic              evAddr,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic              rxRw,
  input  logic              matchAux,
  input  logic              evDataDone,
  input  logic              evAckDone,
  input  logic              ackN,
  input  logic              evTmo,
  input  logic [1:0]        tmoKind,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] rangeAddr,
  input  logic              rangeEn,
  input  logic              intEn,
  input  logic              ssIntEn,
  input  logic              fastAck,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output statStrobes_t      strb
);
  logic wrStat, wrCtrl, wrSsf;
  logic primHit, rangeHit, anyHit, byteEvt, tmoCounts;
  logic unusedData;

  assign wrStat = regWrEn && (regAddr == OFF_STAT);
  assign wrCtrl = regWrEn && (regAddr == OFF_CTRL);
  assign wrSsf  = regWrEn && (regAddr == OFF_SSF);
  assign unusedData = &{1'b0, regWrData[7:5], regWrData[3:2]};

  assign primHit  = evAddr && (rxAddr == ownAddr);
  assign rangeHit = evAddr && rangeEn && (rxAddr != '0) &&
                    ((rxAddr == rangeAddr) || ((rxAddr > ownAddr) && (rxAddr < rangeAddr)));
  assign anyHit   = primHit || rangeHit || (evAddr && matchAux);
  assign byteEvt  = fastAck ? evDataDone : evAckDone;
  assign tmoCounts = evTmo && (tmoKind != 2'd1) && (tmoKind != 2'd2);

  always_comb begin
    strb = '0;
    strb.setBusy   = evStart;
    strb.clrBusy   = evStop;
    strb.setArbl   = evArbLost;
    strb.clrArbl   = wrStat && regWrData[B_ARBL];
    strb.setRange  = rangeHit && intEn;
    strb.clrRange  = wrCtrl;
    strb.ldSrw     = anyHit;
    strb.srwVal    = rxRw;
    strb.setIflag  = byteEvt || anyHit || evArbLost || tmoCounts ||
                     (ssIntEn && (evStart || evStop));
    strb.clrIflag  = wrStat && regWrData[B_IFLAG];
    strb.ldRxak    = evAckDone;
    strb.rxakVal   = ackN;
    strb.setStartF = evStart;
    strb.clrStartF = wrSsf && regWrData[B_STARTF];
    strb.setStopF  = evStop;
    strb.clrStopF  = wrSsf && regWrData[B_STOPF];
  end
endmodule

// File: rtl/i2c_stat_regs.sv
module i2c_stat_regs
  import i2c_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  statStrobes_t     strb,
  input  logic             ssIntEn,
  input  logic             intEn,
  input  logic [1:0]       regAddr,
  output logic [REG_W-1:0] statBits,
  output logic [REG_W-1:0] regRdData,
  output logic             irq
);
  logic busy, arbl, rangeHitF, srw, iflag, rxak, startF, stopF;
  logic ssHold;

  assign ssHold = ssIntEn && (startF || stopF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; arbl <= 1'b0; rangeHitF <= 1'b0; srw <= 1'b0;
      iflag <= 1'b0; rxak <= 1'b0; startF <= 1'b0; stopF <= 1'b0;
    end else begin
      busy      <= strb.setBusy || (busy && !strb.clrBusy);
      arbl      <= strb.setArbl || (arbl && !strb.clrArbl);
      rangeHitF <= strb.setRange || (rangeHitF && !strb.clrRange);
      iflag     <= strb.setIflag || ssHold || (iflag && !strb.clrIflag);
      startF    <= strb.setStartF || (startF && !strb.clrStartF);
      stopF     <= strb.setStopF || (stopF && !strb.clrStopF);
      if (strb.ldSrw)  srw  <= strb.srwVal;
      if (strb.ldRxak) rxak <= strb.rxakVal;
    end
  end

  always_comb begin
    statBits = '0;
    statBits[B_BUSY]  = busy;
    statBits[B_ARBL]  = arbl;
    statBits[B_RANGE] = rangeHitF;
    statBits[B_SRW]   = srw;
    statBits[B_IFLAG] = iflag;
    statBits[B_RXAK]  = rxak;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFF_STAT: regRdData = statBits;
      OFF_SSF: begin
        regRdData[B_STARTF] = startF;
        regRdData[B_STOPF]  = stopF;
      end
      default: regRdData = '0;
    endcase
  end

  assign irq = iflag && intEn;
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evArbLost,
  input  logic              evAddr,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic              rxRw,
  input  logic              matchAux,
  input  logic              evDataDone,
  input  logic              evAckDone,
  input  logic              ackN,
  input  logic              evTmo,
  input  logic [1:0]        tmoKind,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] rangeAddr,
  input  logic              rangeEn,
  input  logic              intEn,
  input  logic              ssIntEn,
  input  logic              fastAck,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              irq
);
  statStrobes_t strb;
  logic [REG_W-1:0] statBits;

  i2c_stat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .evStart(evStart), .evStop(evStop), .evArbLost(evArbLost),
    .evAddr(evAddr), .rxAddr(rxAddr), .rxRw(rxRw), .matchAux(matchAux),
    .evDataDone(evDataDone), .evAckDone(evAckDone), .ackN(ackN),
    .evTmo(evTmo), .tmoKind(tmoKind), .ownAddr(ownAddr),
    .rangeAddr(rangeAddr), .rangeEn(rangeEn), .intEn(intEn),
    .ssIntEn(ssIntEn), .fastAck(fastAck), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .strb(strb)
  );

  i2c_stat_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .ssIntEn(ssIntEn), .intEn(intEn),
    .regAddr(regAddr), .statBits(statBits), .regRdData(regRdData), .irq(irq)
  );
endmodule

// File: rtl/i2c_stat_chk.sv
module i2c_stat_chk (
  input logic       clk,
  input logic       rstN,
  input logic       evStart,
  input logic       evStop,
  input logic       evArbLost,
  input logic       evAddr,
  input logic       intEn,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] statBits,
  input logic       irq
);
  assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    evStart |=> statBits[5]);
  assert_busy_clr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evStop && !evStart) |=> !statBits[5]);
  assert_arbl_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statBits[4] && !(regWrEn && regAddr == 2'd0 && regWrData[4])) |=> statBits[4]);
  assert_range_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && !evAddr) |=> !statBits[3]);
  assert_arb_iflag_R8: assert property (@(posedge clk) disable iff (!rstN)
    evArbLost |=> statBits[1]);
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (evArbLost && regWrEn && regAddr == 2'd0 && regWrData[4]) |=> statBits[4]);
  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intEn);
endmodule

bind i2c_stat_flags i2c_stat_chk u_chk (
  .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
  .evArbLost(evArbLost), .evAddr(evAddr), .intEn(intEn), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrData(regWrData), .statBits(statBits), .irq(irq)
);

// File: tb/tb_i2c_stat_flags.sv
`timescale 1ns/1ps
module tb_i2c_stat_flags;
  logic clk = 0, rstN = 0;
  logic evStart = 0, evStop = 0, evArbLost = 0, evAddr = 0;
  logic [6:0] rxAddr = 0;
  logic rxRw = 0, matchAux = 0, evDataDone = 0, evAckDone = 0, ackN = 0;
  logic evTmo = 0;
  logic [1:0] tmoKind = 0;
  logic [6:0] ownAddr = 7'h20, rangeAddr = 7'h28;
  logic rangeEn = 1, intEn = 1, ssIntEn = 0, fastAck = 0;
  logic regWrEn = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic irq;
  int nVec = 0, nBad = 0;
  logic [7:0] rd;

  always #2 clk = ~clk;

  i2c_stat_flags dut (.*);

  typedef struct packed {
    logic st, sp, arb, adr;
    logic [6:0] ra;
    logic rw, tmo;
    logic [1:0] tk;
    logic wr;
    logic [1:0] wa;
    logic [7:0] wd;
    logic [7:0] expv;
  } vec_t;

  // status bits: 5 busy, 4 arbl, 3 range, 2 srw, 1 iflag, 0 rxak
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0, 7'h00,0, 0,2'd0, 0,2'd0,8'h00, 8'h20},
    '{0,0,0,1, 7'h20,1, 0,2'd0, 0,2'd0,8'h00, 8'h26},
    '{0,0,0,0, 7'h00,0, 0,2'd0, 1,2'd0,8'h02, 8'h24},
    '{0,0,0,1, 7'h24,0, 0,2'd0, 0,2'd0,8'h00, 8'h2A},
    '{0,0,0,0, 7'h00,0, 0,2'd0, 1,2'd1,8'h55, 8'h22},
    '{0,0,0,0, 7'h00,0, 0,2'd0, 1,2'd0,8'h02, 8'h20},
    '{0,0,0,1, 7'h28,1, 0,2'd0, 0,2'd0,8'h00, 8'h2E},
    '{0,0,0,0, 7'h00,0, 0,2'd0, 1,2'd1,8'h00, 8'h26},
    '{0,0,0,0, 7'h00,0, 0,2'd0, 1,2'd0,8'h02, 8'h24},
    '{0,0,0,1, 7'h30,0, 0,2'd0, 0,2'd0,8'h00, 8'h24},
    '{0,0,0,0, 7'h00,0, 1,2'd1, 0,2'd0,8'h00, 8'h24},
    '{0,0,0,0, 7'h00,0, 1,2'd0, 0,2'd0,8'h00, 8'h26},
    '{0,0,1,0, 7'h00,0, 0,2'd0, 0,2'd0,8'h00, 8'h36},
    '{0,0,0,0, 7'h00,0, 0,2'd0, 1,2'd0,8'h12, 8'h24},
    '{0,0,0,0, 7'h00,0, 0,2'd0, 1,2'd0,8'h20, 8'h24},
    '{0,1,0,0, 7'h00,0, 0,2'd0, 0,2'd0,8'h00, 8'h04}
  };
  string vecTag [NV] = '{"R2","R6","R8","R4","R5","R8","R4","R5",
                         "R8","R6","R8","R8","R3","R3","R2","R2"};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] expv);
    nVec++;
    if (got !== expv) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic endCycle;
    @(negedge clk);
    {evStart, evStop, evArbLost, evAddr, evDataDone, evAckDone, evTmo, regWrEn} = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    endCycle();
  endtask

  initial begin
    #(200000 * 4);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    readReg(2'd0, rd); chk("R1 status", rd, 8'h00);
    readReg(2'd2, rd); chk("R1 ssflags", rd, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rstN = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evStart = VECS[i].st; evStop = VECS[i].sp; evArbLost = VECS[i].arb;
      evAddr = VECS[i].adr; rxAddr = VECS[i].ra; rxRw = VECS[i].rw;
      evTmo = VECS[i].tmo; tmoKind = VECS[i].tk;
      regWrEn = VECS[i].wr; regAddr = VECS[i].wa; regWrData = VECS[i].wd;
      endCycle();
      readReg(2'd0, rd); chk(vecTag[i], rd, VECS[i].expv);
    end
    // clear start/stop flags left by the table
    wr(2'd2, 8'h03);

    // R7: fast-ACK off
    wr(2'd0, 8'h02);
    @(negedge clk); evDataDone = 1; endCycle();
    readReg(2'd0, rd); chk("R7 noack data", rd & 8'h02, 8'h00);
    @(negedge clk); evAckDone = 1; ackN = 1; endCycle();
    readReg(2'd0, rd); chk("R7 ack done", rd & 8'h03, 8'h03);
    // R7: fast-ACK on
    fastAck = 1; wr(2'd0, 8'h02);
    @(negedge clk); evDataDone = 1; endCycle();
    readReg(2'd0, rd); chk("R7 fast data", rd & 8'h03, 8'h03);
    wr(2'd0, 8'h02);
    @(negedge clk); evAckDone = 1; ackN = 0; endCycle();
    readReg(2'd0, rd); chk("R10 ack sample", rd & 8'h03, 8'h00);
    fastAck = 0;

    // R11: set and clear in same cycle
    @(negedge clk);
    evArbLost = 1; regWrEn = 1; regAddr = 2'd0; regWrData = 8'h12;
    endCycle();
    readReg(2'd0, rd); chk("R11 set wins", rd & 8'h12, 8'h12);

    // R12
    intEn = 0; #1; chk("R12 gated", {7'd0, irq}, 8'h00);
    intEn = 1; #1; chk("R12 pass", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h12);

    // R4: no range match with intEn low
    intEn = 0;
    @(negedge clk); evAddr = 1; rxAddr = 7'h24; rxRw = 1; endCycle();
    readReg(2'd0, rd); chk("R4 intEn low", rd & 8'h0C, 8'h04);
    intEn = 1; wr(2'd0, 8'h02);

    // R9: start/stop interrupt and clear order
    ssIntEn = 1;
    @(negedge clk); evStop = 1; endCycle();
    readReg(2'd2, rd); chk("R9 stop flag", rd, 8'h01);
    readReg(2'd0, rd); chk("R9 stop iflag", rd & 8'h22, 8'h02);
    wr(2'd0, 8'h02);
    readReg(2'd0, rd); chk("R9 reraise", rd & 8'h02, 8'h02);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h02);
    readReg(2'd0, rd); chk("R9 cleared", rd & 8'h02, 8'h00);
    ssIntEn = 0;
    @(negedge clk); evStart = 1; endCycle();
    readReg(2'd2, rd); chk("R9 start flag", rd, 8'h02);
    readReg(2'd0, rd); chk("R9 no int", rd & 8'h02, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule